// File: doc/BRIEF.md
# Byte-Exchange Serial Peripheral Controller

This block is a byte-wide SPI peripheral driven through a small register interface. Software sets a control register to enable it and to choose master or slave role. When the block is an enabled master, a write to the data register launches one eight-bit full-duplex exchange. The block drives the serial clock, and the written byte leaves on MOSI while the far side's byte arrives on MISO. In slave role the block shifts only while its select input is low, and it answers on MISO with a byte that software loaded beforehand.

The transmit path has a single buffer, so a data write during an exchange is refused and flagged as a collision. The receive path has two buffers: every finished byte is copied into a read buffer, which the next finished byte overwrites if software has not read it. An idle master that sees its select input pulled low by another master gives up the master role on its own and becomes a selected slave. The serial clock is fixed to mode 0: it idles low, data is sampled on the rising edge and changed on the falling edge, and bits go MSB first. The clock period is set by a parameter.

The register port is a plain single-cycle write strobe with a combinational read. It has no handshake and never stalls.

Top module: `spi_ctrl`

## Requirements
- R1: After reset all registers read 0, sclk_o is low, mosi_o is high and irq is low.
- R2: Register map: address 0 is control (bit0 enable, bit1 master select, bit2 select-ignore, bit3 interrupt enable), address 1 is status (bit0 byte done, bit1 write collision), address 2 is data. With control showing enable=1, master select=1, select-ignore=0 and ss_n_i high, a data write starts an exchange. MOSI shows the MSB DIV clocks after the write edge, and sclk_o idles low with a period of 2*DIV clocks.
- R3: An exchange is full duplex and MSB first. The eight bits on mosi_o equal the written byte, and the data register then reads the byte presented on miso_i, sampled on rising sclk_o edges.
- R4: Each finished byte sets status bit0. irq equals that bit ANDed with control bit3. Writing 1 to status bit0 clears it, and irq falls with it.
- R5: A data write while an exchange is in progress sets status bit1 and is discarded, and the byte in flight completes unchanged. Writing 1 to status bit1 clears it.
- R6: If ss_n_i goes low while the block is an idle enabled master with select-ignore clear, hardware clears control bit1. sclk_oe and mosi_oe drop and miso_oe rises.
- R7: As an enabled non-master with ss_n_i low, the block samples mosi_i on rising sclk_i and shifts on falling sclk_i. It presents the preloaded data byte MSB first on miso_o, and after eight bits the data register reads the received byte.
- R8: ss_n_i rising in the middle of a slave byte abandons it. No done flag is set, and the next full byte is received aligned.
- R9: A received byte that has not been read is overwritten by the next finished byte.
- R10: With enable=0 a data write starts nothing: sclk_o stays low and status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master role |
| sclk_oe | output | 1 | Enable for sclk_o |
| mosi_o | output | 1 | Serial data out in master role |
| mosi_oe | output | 1 | Enable for mosi_o |
| miso_o | output | 1 | Serial data out in slave role |
| miso_oe | output | 1 | Enable for miso_o |
| sclk_i | input | 1 | Serial clock in slave role |
| mosi_i | input | 1 | Serial data in slave role |
| miso_i | input | 1 | Serial data in master role |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The bench builds the block with DIV=4 and eight-bit bytes. This size makes it cheap to sweep all 256 byte values, each against a computed partner byte, in both master and slave roles. With DIV=4 the serial clock stays high for four system clocks, which leaves enough room to insert a data write in the middle of a transfer and to measure exactly when the MSB first appears.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic irq_en;
    logic ss_ignore;
    logic master_sel;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] init_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta, held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= init_i[g];
        held <= init_i[g];
      end else begin
        meta <= d_i[g];
        held <= meta;
      end
    end
    assign q_o[g] = held;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          slave_sel_i,
  input  logic          s_sclk_i,
  input  logic          s_mosi_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_data_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          miso_o
);
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW  = $clog2(2 * DW + 1);
  localparam int NBW = $clog2(DW);

  logic          m_busy, s_active, sclk_r, drive_r, samp, sclk_d;
  logic [CW-1:0] div_cnt;
  logic [EW-1:0] edge_cnt;
  logic [NBW-1:0] s_cnt;
  logic [DW-1:0] shreg;
  logic          tick, s_rise, s_fall;

  assign tick   = m_busy && (div_cnt == CW'(DIV - 1));
  assign s_rise = s_sclk_i && !sclk_d;
  assign s_fall = !s_sclk_i && sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy   <= 1'b0;
      s_active <= 1'b0;
      sclk_r   <= 1'b0;
      drive_r  <= 1'b0;
      samp     <= 1'b0;
      sclk_d   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      s_cnt    <= '0;
      shreg    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      sclk_d <= s_sclk_i;
      if (m_busy) begin
        if (tick) begin
          div_cnt  <= '0;
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == '0) begin
            drive_r <= 1'b1;
          end else if (edge_cnt[0]) begin
            sclk_r <= 1'b1;
            samp   <= miso_i;
          end else begin
            sclk_r <= 1'b0;
            shreg  <= {shreg[DW-2:0], samp};
            if (edge_cnt == EW'(2 * DW)) begin
              m_busy  <= 1'b0;
              drive_r <= 1'b0;
              done_o  <= 1'b1;
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else if (start_i) begin
        m_busy   <= 1'b1;
        div_cnt  <= '0;
        edge_cnt <= '0;
        sclk_r   <= 1'b0;
        drive_r  <= 1'b0;
        shreg    <= load_data_i;
      end else if (!slave_sel_i) begin
        s_cnt    <= '0;
        s_active <= 1'b0;
        if (load_i) shreg <= load_data_i;
      end else if (s_rise) begin
        samp     <= s_mosi_i;
        s_active <= 1'b1;
      end else if (s_fall && s_active) begin
        shreg <= {shreg[DW-2:0], samp};
        if (s_cnt == NBW'(DW - 1)) begin
          s_cnt    <= '0;
          s_active <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          s_cnt <= s_cnt + 1'b1;
        end
      end else if (load_i) begin
        shreg <= load_data_i;
      end
    end
  end

  assign busy_o    = m_busy || s_active;
  assign rx_data_o = shreg;
  assign sclk_o    = sclk_r;
  assign mosi_o    = drive_r ? shreg[DW-1] : 1'b1;
  assign miso_o    = shreg[DW-1];

  // R2: the half-bit edge counter never runs past the last falling edge
  p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |-> (edge_cnt <= EW'(2 * DW)));

  // R2: the serial clock rests low whenever no master exchange runs
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> !sclk_r);

  // R8: losing the select clears any partial slave byte
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel_i && !m_busy) |=> (s_cnt == '0 && !s_active));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          s_ss_n_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          start_o,
  output logic          load_o,
  output logic          master_mode_o,
  output logic          slave_sel_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          done_f, coll_f;
  logic [DW-1:0] rbuf;
  logic          data_wr, coll_ev, drop;

  assign data_wr       = wr_i && (addr_i == ADDR_DATA);
  assign master_mode_o = ctrl.enable && ctrl.master_sel && !ctrl.ss_ignore && s_ss_n_i;
  assign slave_sel_o   = ctrl.enable && !master_mode_o && (!s_ss_n_i || ctrl.ss_ignore);
  assign start_o       = data_wr && master_mode_o && !busy_i;
  assign load_o        = data_wr && ctrl.enable && !busy_i;
  assign coll_ev       = data_wr && ctrl.enable && busy_i;
  assign drop          = ctrl.enable && ctrl.master_sel && !ctrl.ss_ignore &&
                         !s_ss_n_i && !busy_i;
  assign irq_o         = done_f && ctrl.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      done_f <= 1'b0;
      coll_f <= 1'b0;
      rbuf   <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_CTRL) ctrl <= ctrl_t'(wdata_i[3:0]);
      if (drop) ctrl.master_sel <= 1'b0;
      if (done_i) begin
        done_f <= 1'b1;
        rbuf   <= rx_data_i;
      end else if (wr_i && addr_i == ADDR_STAT && wdata_i[0]) begin
        done_f <= 1'b0;
      end
      if (coll_ev) coll_f <= 1'b1;
      else if (wr_i && addr_i == ADDR_STAT && wdata_i[1]) coll_f <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o[3:0] = ctrl;
      ADDR_STAT: rdata_o[1:0] = {coll_f, done_f};
      ADDR_DATA: rdata_o      = rbuf;
      default:   rdata_o      = '0;
    endcase
  end

  // R4: a finished byte always raises the done flag
  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> done_f);

  // R5: a refused data write always leaves the collision flag set
  p_coll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_ev |=> coll_f);

  // R6: an idle master selected from outside loses master select
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !ctrl.master_sel);

  // R9: the read buffer takes the newest finished byte
  p_rbuf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (rbuf == $past(rx_data_i)));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          sclk_o,
  output logic          sclk_oe,
  output logic          mosi_o,
  output logic          mosi_oe,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  logic [2:0]    synced;
  logic          s_ss_n, s_sclk, s_mosi;
  logic          busy, done, start, load, master_mode, slave_sel;
  logic [DW-1:0] rx_data;

  spi_sync #(.W(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({ss_n_i, sclk_i, mosi_i}),
    .init_i (3'b100),
    .q_o    (synced)
  );
  assign {s_ss_n, s_sclk, s_mosi} = synced;

  spi_regs #(.DW(DW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (reg_wr),
    .addr_i        (reg_addr),
    .wdata_i       (reg_wdata),
    .rdata_o       (reg_rdata),
    .s_ss_n_i      (s_ss_n),
    .busy_i        (busy),
    .done_i        (done),
    .rx_data_i     (rx_data),
    .start_o       (start),
    .load_o        (load),
    .master_mode_o (master_mode),
    .slave_sel_o   (slave_sel),
    .irq_o         (irq)
  );

  spi_shifter #(.DW(DW), .DIV(DIV)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .load_i      (load),
    .load_data_i (reg_wdata),
    .slave_sel_i (slave_sel),
    .s_sclk_i    (s_sclk),
    .s_mosi_i    (s_mosi),
    .miso_i      (miso_i),
    .busy_o      (busy),
    .done_o      (done),
    .rx_data_o   (rx_data),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .miso_o      (miso_o)
  );

  assign sclk_oe = master_mode;
  assign mosi_oe = master_mode;
  assign miso_oe = slave_sel;
endmodule

// File: tb/spi_ctrl_tb.sv
`timescale 1ns/1ps
module spi_ctrl_tb;
  localparam int DW = 8;
  localparam int DIV = 4;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_ctrl #(.DW(DW), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_o(miso_o), .miso_oe(miso_oe), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // bench acts as slave; optionally writes data mid-byte
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] slv,
                             input bit coll, output logic [7:0] got, output int lat);
    logic [7:0] s = slv;
    miso_i = s[7];
    wr(2'd2, tx);
    lat = 0;
    if (!tx[7]) while (mosi_o !== 1'b0 && lat < 4 * DIV) begin
      @(negedge clk); lat++;
    end
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk_o);
      got[7 - i] = mosi_o;
      if (coll && i == 2) wr(2'd2, ~tx);
      @(negedge sclk_o);
      s = {s[6:0], 1'b0};
      miso_i = s[7];
    end
    repeat (3) @(negedge clk);
  endtask

  // bench acts as master on the slave-side pins
  task automatic slave_xfer(input logic [7:0] mtx, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mtx[7 - i];
      repeat (HALF) @(negedge clk);
      got[7 - i] = miso_o;
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, st;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 status", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 data", d, 0);
    chk(sclk_o == 0 && mosi_o == 1 && irq == 0, "R1 pins", {sclk_o, mosi_o, irq}, 3'b010);

    // R10 disabled block ignores data writes
    wr(2'd2, 8'h3C);
    repeat (40) begin @(negedge clk); if (sclk_o) break; end
    chk(sclk_o == 0, "R10 sclk", sclk_o, 0);
    rd(2'd1, d); chk(d == 0, "R10 status", d, 0);

    // R2 R3 R4 master sweep over every byte
    wr(2'd0, 8'h0B);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] slv = 8'((v * 37 + 11) & 255);
      master_xfer(8'(v), slv, 1'b0, got, lat);
      chk(got == 8'(v), "R3 mosi bits", got, v);
      if (v[7] == 0) chk(lat == DIV, "R2 first bit latency", lat, DIV);
      rd(2'd2, d); chk(d == slv, "R3 rx byte", d, slv);
      rd(2'd1, st); chk(st == 8'h01, "R4 done flag", st, 1);
      chk(irq == 1, "R4 irq set", irq, 1);
      wr(2'd1, 8'h01);
      @(negedge clk);
      chk(irq == 0, "R4 irq cleared", irq, 0);
    end
    rd(2'd1, d); chk(d == 0, "R4 w1c", d, 0);

    // R5 collision
    master_xfer(8'h96, 8'h4D, 1'b1, got, lat);
    chk(got == 8'h96, "R5 byte in flight", got, 8'h96);
    rd(2'd1, d); chk(d == 8'h03, "R5 status", d, 3);
    rd(2'd2, d); chk(d == 8'h4D, "R5 rx", d, 8'h4D);
    wr(2'd1, 8'h02);
    rd(2'd1, d); chk(d == 8'h01, "R5 w1c", d, 1);
    wr(2'd1, 8'h01);

    // R6 mode drop
    wr(2'd0, 8'h03);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h01, "R6 master cleared", d, 1);
    chk({sclk_oe, mosi_oe, miso_oe} == 3'b001, "R6 enables", {sclk_oe, mosi_oe, miso_oe}, 1);

    // R7 slave sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pre = 8'(v) ^ 8'h5A;
      wr(2'd2, pre);
      slave_xfer(8'(v), 8, got);
      chk(got == pre, "R7 miso bits", got, pre);
      rd(2'd2, d); chk(d == 8'(v), "R7 rx byte", d, v);
      rd(2'd1, d); chk(d == 8'h01, "R7 done", d, 1);
      wr(2'd1, 8'h01);
    end

    // R8 select abort mid byte
    wr(2'd2, 8'hF0);
    slave_xfer(8'hFF, 3, got);
    ss_n_i = 1'b1; repeat (6) @(negedge clk);
    ss_n_i = 1'b0; repeat (6) @(negedge clk);
    rd(2'd1, d); chk(d == 0, "R8 no done", d, 0);
    wr(2'd2, 8'h3E);
    slave_xfer(8'hA5, 8, got);
    chk(got == 8'h3E, "R8 miso aligned", got, 8'h3E);
    rd(2'd2, d); chk(d == 8'hA5, "R8 rx aligned", d, 8'hA5);
    wr(2'd1, 8'h01);

    // R9 overrun keeps newest
    wr(2'd2, 8'h00);
    slave_xfer(8'h11, 8, got);
    wr(2'd2, 8'h00);
    slave_xfer(8'h22, 8, got);
    rd(2'd2, d); chk(d == 8'h22, "R9 overwrite", d, 8'h22);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule